// File: doc/BRIEF.md
# Guarded Configuration Register

This block is a single configuration register reached over a two-wire serial bus. It sits behind a byte-level slave front end. The front end reports start and stop conditions, delivers each received byte, and asks for read data. The block returns an acknowledge decision for every byte and supplies the byte that is read. The register holds five persistent settings: two power-up delay bits, two watchdog period bits and a block-protect bit. It also holds two volatile enable latches. These latches must be armed in order before the persistent settings may change.

A transaction opens with a device-type byte. Its upper nibble is a fixed code (default 4'b1011). Bit 1 carries address bit 8 and bit 0 is the read/write flag. An address byte with the low eight address bits follows. A write then takes exactly one data byte. That byte acts only when the stop condition arrives. A committed change starts a modelled storage cycle, and every access is refused until the cycle ends. A random read sets the address pointer with a write-mode header, repeats the start, and fetches one byte.

Top module: `cfgreg_guard`

## Requirements
- R1: A byte is acknowledged only when its header has the upper nibble DEV_CODE (default 4'b1011) and the 9-bit address {header bit 1, address byte} equals REG_ADDR (default 9'h1FF). Header bit 0 = 1 selects read. A wrong code, a wrong address, or a read header while the pointer is not REG_ADDR is not acknowledged.
- R2: The read byte is, from bit 7 to bit 0: PUP1, WD1, WD0, BP, 0, RWEL, WEL, PUP0.
- R3: A committed data byte with bit 2 = 0, written while RWEL is clear, loads WEL from bit 1. The persistent fields do not change; this is how a step-3 write without RWEL is discarded.
- R4: A committed byte with bits 2 and 1 both 1 sets RWEL only if WEL is already 1. Otherwise it has no effect. RWEL is never 1 while WEL is 0.
- R5: A committed byte with bit 2 = 0, written while RWEL is 1, loads PUP1, WD1, WD0, BP and PUP0 from bits 7, 6, 5, 4 and 0. It clears RWEL and leaves WEL at 1.
- R6: Only the first data byte of a write is acknowledged. Later bytes are not acknowledged and have no effect.
- R7: A data byte acts only on the stop that ends its transaction. A repeated start before the stop discards it.
- R8: After a persistent update, busy is high for exactly COMMIT_CYCLES cycles, starting the cycle after the stop. While busy is high, no byte is acknowledged.
- R9: The power reset loads the persistent fields from PERSIST_INIT and clears both latches. The volatile reset clears WEL and RWEL only.
- R10: A read returns one byte. rd_ok is high only for the first read request after an acknowledged read header.
- R11: Bit 3 always reads 0, and writing a 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power reset, active low; also initialises the persistent fields |
| rst_n | input | 1 | Volatile reset, active low; clears the latches and the sequencer |
| bus_start | input | 1 | Start or repeated-start event, one cycle |
| bus_stop | input | 1 | Stop event, one cycle |
| rx_valid | input | 1 | Received byte valid, one cycle |
| rx_byte | input | 8 | Received byte |
| ack_out | output | 1 | Acknowledge decision for the byte on rx_byte (combinational) |
| rd_req | input | 1 | Read data request, one cycle |
| rd_ok | output | 1 | Read request honoured this cycle |
| rd_data | output | 8 | Current register view |
| busy | output | 1 | Storage cycle in progress |

## Verification
The bench builds the block with COMMIT_CYCLES = 6 and the defaults for the code, the address and the initial value (all persistent bits 0). A short storage cycle lets the bench count the exact length of every busy window. It also lets the bench start a new header in the first busy cycle to confirm it is refused. The all-zero initial value makes each committed field visible as a change. A vector table walks the three-step enable sequence through its legal steps and its out-of-order steps. Directed cases then cover extra data bytes, a missing stop, bad headers and addresses, a double read, and both resets.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HDR,
      S_ADDR,
      S_DATA,
      S_EXTRA,
      S_READ,
      S_SKIP
   } txn_state_t;

   typedef struct packed {
      logic pup1;
      logic wd1;
      logic wd0;
      logic bp;
      logic pup0;
   } persist_t;

   localparam int BIT_RWEL = 2;
   localparam int BIT_WEL  = 1;

   function automatic logic [7:0] reg_view(persist_t p, logic rwel, logic wel);
      return {p.pup1, p.wd1, p.wd0, p.bp, 1'b0, rwel, wel, p.pup0};
   endfunction

   function automatic persist_t take_fields(logic [7:0] b);
      persist_t p;
      p.pup1 = b[7];
      p.wd1  = b[6];
      p.wd0  = b[5];
      p.bp   = b[4];
      p.pup0 = b[0];
      return p;
   endfunction

endpackage

// File: rtl/cfgreg_seq.sv
module cfgreg_seq
   import cfgreg_pkg::*;
#(
   parameter int         ADDR_W   = 9,
   parameter logic [3:0] DEV_CODE = 4'b1011,
   parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
   input  logic       clk,
   input  logic       vrst_n,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       rd_req,
   input  logic       busy,
   output logic       ack_out,
   output logic       rd_ok,
   output logic       wr_fire,
   output logic [7:0] wr_byte
);
   localparam int HI_W = ADDR_W - 8;

   txn_state_t        st_q, st_d;
   logic [HI_W-1:0]   hi_q, hi_d;
   logic [ADDR_W-1:0] ptr_q, ptr_d;
   logic [7:0]        pend_q, pend_d;

   always_comb begin
      st_d    = st_q;
      hi_d    = hi_q;
      ptr_d   = ptr_q;
      pend_d  = pend_q;
      ack_out = 1'b0;
      rd_ok   = 1'b0;
      wr_fire = 1'b0;
      if (bus_stop) begin
         st_d    = S_IDLE;
         wr_fire = (st_q == S_EXTRA);
      end else if (bus_start) begin
         st_d = S_HDR;
      end else if (rx_valid) begin
         unique case (st_q)
            S_HDR: begin
               st_d = S_SKIP;
               if (!busy && rx_byte[7:4] == DEV_CODE) begin
                  if (rx_byte[0]) begin
                     if (ptr_q == REG_ADDR) begin
                        ack_out = 1'b1;
                        st_d    = S_READ;
                     end
                  end else begin
                     ack_out = 1'b1;
                     hi_d    = rx_byte[HI_W:1];
                     st_d    = S_ADDR;
                  end
               end
            end
            S_ADDR: begin
               ptr_d = {hi_q, rx_byte};
               if ({hi_q, rx_byte} == REG_ADDR) begin
                  ack_out = 1'b1;
                  st_d    = S_DATA;
               end else begin
                  st_d = S_SKIP;
               end
            end
            S_DATA: begin
               ack_out = 1'b1;
               pend_d  = rx_byte;
               st_d    = S_EXTRA;
            end
            default: st_d = st_q;
         endcase
      end else if (rd_req && st_q == S_READ) begin
         rd_ok = 1'b1;
         st_d  = S_SKIP;
      end
   end

   always_ff @(posedge clk or negedge vrst_n) begin
      if (!vrst_n) begin
         st_q   <= S_IDLE;
         hi_q   <= '0;
         ptr_q  <= '0;
         pend_q <= '0;
      end else begin
         st_q   <= st_d;
         hi_q   <= hi_d;
         ptr_q  <= ptr_d;
         pend_q <= pend_d;
      end
   end

   assign wr_byte = pend_q;

endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
   import cfgreg_pkg::*;
#(
   parameter logic [4:0] PERSIST_INIT = 5'b0
) (
   input  logic       clk,
   input  logic       pwr_rst_n,
   input  logic       vrst_n,
   input  logic       wr_fire,
   input  logic [7:0] wr_byte,
   output persist_t   pers,
   output logic       wel,
   output logic       rwel,
   output logic       commit
);
   persist_t pers_q;
   logic     wel_q, rwel_q;

   assign commit = wr_fire && rwel_q && !wr_byte[BIT_RWEL];

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         pers_q <= persist_t'(PERSIST_INIT);
      end else if (commit) begin
         pers_q <= take_fields(wr_byte);
      end
   end

   always_ff @(posedge clk or negedge vrst_n) begin
      if (!vrst_n) begin
         wel_q  <= 1'b0;
         rwel_q <= 1'b0;
      end else if (wr_fire) begin
         if (commit) begin
            rwel_q <= 1'b0;
         end else if (!wr_byte[BIT_RWEL]) begin
            wel_q <= wr_byte[BIT_WEL];
         end else if (wr_byte[BIT_WEL] && wel_q) begin
            rwel_q <= 1'b1;
         end
      end
   end

   assign pers = pers_q;
   assign wel  = wel_q;
   assign rwel = rwel_q;

endmodule

// File: rtl/cfgreg_timer.sv
module cfgreg_timer #(
   parameter int COMMIT_CYCLES = 20
) (
   input  logic clk,
   input  logic pwr_rst_n,
   input  logic commit,
   output logic busy
);
   localparam int CNT_W = (COMMIT_CYCLES < 1) ? 1 : $clog2(COMMIT_CYCLES + 1);

   if (COMMIT_CYCLES == 0) begin : g_instant
      assign busy = 1'b0;
   end else begin : g_counted
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge pwr_rst_n) begin
         if (!pwr_rst_n) begin
            cnt_q <= '0;
         end else if (commit) begin
            cnt_q <= CNT_W'(COMMIT_CYCLES);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
      assign busy = (cnt_q != '0);
   end

endmodule

// File: rtl/cfgreg_guard.sv
module cfgreg_guard
   import cfgreg_pkg::*;
#(
   parameter int         ADDR_W        = 9,
   parameter logic [3:0] DEV_CODE      = 4'b1011,
   parameter logic [ADDR_W-1:0] REG_ADDR = '1,
   parameter int         COMMIT_CYCLES = 20,
   parameter logic [4:0] PERSIST_INIT  = 5'b0
) (
   input  logic       clk,
   input  logic       pwr_rst_n,
   input  logic       rst_n,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic       ack_out,
   input  logic       rd_req,
   output logic       rd_ok,
   output logic [7:0] rd_data,
   output logic       busy
);
   if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr_w
      $error("cfgreg_guard: ADDR_W must lie in 9..11");
   end
   if (COMMIT_CYCLES < 0) begin : g_bad_cycles
      $error("cfgreg_guard: COMMIT_CYCLES must not be negative");
   end

   logic       vrst_n;
   logic       wr_fire, commit, wel, rwel;
   logic [7:0] wr_byte;
   persist_t   pers;

   assign vrst_n = rst_n & pwr_rst_n;

   cfgreg_seq #(
      .ADDR_W  (ADDR_W),
      .DEV_CODE(DEV_CODE),
      .REG_ADDR(REG_ADDR)
   ) u_seq (
      .clk      (clk),
      .vrst_n   (vrst_n),
      .bus_start(bus_start),
      .bus_stop (bus_stop),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .rd_req   (rd_req),
      .busy     (busy),
      .ack_out  (ack_out),
      .rd_ok    (rd_ok),
      .wr_fire  (wr_fire),
      .wr_byte  (wr_byte)
   );

   cfgreg_store #(
      .PERSIST_INIT(PERSIST_INIT)
   ) u_store (
      .clk      (clk),
      .pwr_rst_n(pwr_rst_n),
      .vrst_n   (vrst_n),
      .wr_fire  (wr_fire),
      .wr_byte  (wr_byte),
      .pers     (pers),
      .wel      (wel),
      .rwel     (rwel),
      .commit   (commit)
   );

   cfgreg_timer #(
      .COMMIT_CYCLES(COMMIT_CYCLES)
   ) u_timer (
      .clk      (clk),
      .pwr_rst_n(pwr_rst_n),
      .commit   (commit),
      .busy     (busy)
   );

   assign rd_data = reg_view(pers, rwel, wel);

endmodule

// File: rtl/cfgreg_guard_chk.sv
module cfgreg_guard_chk #(
   parameter int COMMIT_CYCLES = 20
) (
   input logic       clk,
   input logic       pwr_rst_n,
   input logic       rst_n,
   input logic       bus_stop,
   input logic       ack_out,
   input logic       busy,
   input logic [7:0] rd_data
);
   logic [4:0] pers_view;
   assign pers_view = {rd_data[7:4], rd_data[0]};

   assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      busy |-> !ack_out);

   assert_persist_hold_R7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !bus_stop |=> $stable(pers_view));

   assert_rwel_needs_wel_R4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      rd_data[2] |-> rd_data[1]);

   assert_vol_clear_R9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !rst_n |=> (rd_data[2:1] == 2'b00));

   if (COMMIT_CYCLES > 0) begin : g_busy_chk
      assert_commit_busy_R8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
         !$stable(pers_view) |-> busy);
   end

endmodule

bind cfgreg_guard cfgreg_guard_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
   .clk      (clk),
   .pwr_rst_n(pwr_rst_n),
   .rst_n    (rst_n),
   .bus_stop (bus_stop),
   .ack_out  (ack_out),
   .busy     (busy),
   .rd_data  (rd_data)
);

// File: tb/cfgreg_guard_tb.sv
module cfgreg_guard_tb;
   localparam int CYC = 6;

   logic       clk = 1'b0;
   logic       pwr_rst_n = 1'b0, rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       ack_out, rd_ok, busy;
   logic [7:0] rd_data;

   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   cfgreg_guard #(.COMMIT_CYCLES(CYC)) u_dut (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .ack_out(ack_out),
      .rd_req(rd_req), .rd_ok(rd_ok), .rd_data(rd_data), .busy(busy)
   );

   // {data byte, expected register after the write, commit expected}
   localparam logic [16:0] VEC [8] = '{
      {8'h02, 8'h02, 1'b0},   // R3 step 1 sets WEL
      {8'h06, 8'h06, 1'b0},   // R4 step 2 sets RWEL
      {8'hF9, 8'hF3, 1'b1},   // R5 commit, R11 bit 3 dropped
      {8'hA1, 8'hF1, 1'b0},   // R3 without RWEL: discarded, WEL loaded 0
      {8'h06, 8'hF1, 1'b0},   // R4 RWEL refused while WEL is 0
      {8'h02, 8'hF3, 1'b0},   // R3
      {8'h06, 8'hF7, 1'b0},   // R4
      {8'h50, 8'h52, 1'b1}    // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put_start();
      bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic put_stop();
      bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] b, output logic a);
      rx_valid = 1'b1; rx_byte = b; #1 a = ack_out;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic get_byte(output logic ok, output logic [7:0] d);
      rd_req = 1'b1; #1 ok = rd_ok; d = rd_data;
      @(negedge clk); rd_req = 1'b0;
   endtask

   function automatic logic [7:0] hdr(input logic [8:0] addr, input logic rd);
      return {4'b1011, 2'b00, addr[8], rd};
   endfunction

   task automatic write_txn(input logic [8:0] addr, input logic [7:0] data, input int extra,
                            input logic stop, output logic a_hdr, output logic a_addr,
                            output logic a_data, output logic a_extra);
      logic a;
      put_start();
      put_byte(hdr(addr, 1'b0), a_hdr);
      put_byte(addr[7:0], a_addr);
      put_byte(data, a_data);
      a_extra = 1'b0;
      for (int i = 0; i < extra; i++) begin
         put_byte(8'hFF, a);
         a_extra = a_extra | a;
      end
      if (stop) put_stop();
   endtask

   task automatic read_txn(input logic [8:0] addr, output logic a_rd, output logic ok,
                           output logic [7:0] d);
      logic a1, a2;
      put_start();
      put_byte(hdr(addr, 1'b0), a1);
      put_byte(addr[7:0], a2);
      put_start();
      put_byte(hdr(addr, 1'b1), a_rd);
      get_byte(ok, d);
      put_stop();
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic ah, aa, ad, ae, ok;
      logic [7:0] d;
      int n;

      repeat (3) @(negedge clk);
      pwr_rst_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      check("R9 power reset value", rd_data, 8'h00);
      check("R8 idle after reset", busy, 1'b0);

      for (int v = 0; v < 8; v++) begin
         write_txn(9'h1FF, VEC[v][16:9], 0, 1'b1, ah, aa, ad, ae);
         check("R1 header ack", ah, 1'b1);
         check("R1 address ack", aa, 1'b1);
         check("R6 first data ack", ad, 1'b1);
         count_busy(n);
         check("R8 busy length", n, VEC[v][0] ? CYC : 0);
         read_txn(9'h1FF, ah, ok, d);
         check("R10 read ack", {ah, ok}, 2'b11);
         check("R2 R3 R4 R5 R11 register value", d, VEC[v][8:1]);
      end

      // R6: extra data bytes are refused and ignored
      write_txn(9'h1FF, 8'h06, 0, 1'b1, ah, aa, ad, ae);
      write_txn(9'h1FF, 8'h81, 2, 1'b1, ah, aa, ad, ae);
      check("R6 extra bytes nacked", ae, 1'b0);
      count_busy(n);
      read_txn(9'h1FF, ah, ok, d);
      check("R6 only first byte used", d, 8'h83);

      // R8: refused during storage cycle
      write_txn(9'h1FF, 8'h06, 0, 1'b1, ah, aa, ad, ae);
      write_txn(9'h1FF, 8'h10, 0, 1'b1, ah, aa, ad, ae);
      check("R8 busy after commit", busy, 1'b1);
      put_start();
      put_byte(hdr(9'h1FF, 1'b0), ah);
      check("R8 header nacked while busy", ah, 1'b0);
      put_stop();
      count_busy(n);
      read_txn(9'h1FF, ah, ok, d);
      check("R8 value after busy", d, 8'h12);

      // R7: no stop means no effect
      write_txn(9'h1FF, 8'h06, 0, 1'b1, ah, aa, ad, ae);
      write_txn(9'h1FF, 8'hE0, 0, 1'b0, ah, aa, ad, ae);
      read_txn(9'h1FF, ah, ok, d);
      check("R7 pending byte discarded", d, 8'h16);
      check("R7 no storage cycle", busy, 1'b0);

      // R1: wrong code, wrong address, read with a stale pointer
      put_start();
      put_byte(8'h92, ah);
      check("R1 wrong code nacked", ah, 1'b0);
      put_stop();
      write_txn(9'h0FF, 8'h00, 0, 1'b1, ah, aa, ad, ae);
      check("R1 header ack", ah, 1'b1);
      check("R1 wrong address nacked", aa, 1'b0);
      put_start();
      put_byte(hdr(9'h1FF, 1'b1), ah);
      check("R1 read with stale pointer nacked", ah, 1'b0);
      put_stop();

      // R10: a second request in one read is not honoured
      put_start();
      put_byte(hdr(9'h1FF, 1'b0), ah);
      put_byte(8'hFF, aa);
      put_start();
      put_byte(hdr(9'h1FF, 1'b1), ah);
      get_byte(ok, d);
      check("R10 first read", {ok, d}, {1'b1, 8'h16});
      get_byte(ok, d);
      check("R10 second read refused", ok, 1'b0);
      put_stop();

      // R9: volatile reset keeps persistent fields
      rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
      check("R9 volatile reset", rd_data, 8'h10);
      pwr_rst_n = 1'b0; @(negedge clk); pwr_rst_n = 1'b1; @(negedge clk);
      check("R9 power reset reload", rd_data, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule